// File: doc/BRIEF.md
# Wake and Sleep Power Controller

This block decides whether the switched regulators of a multi-rail supply are enabled. It watches a wake input, which turns the supply on either by staying high or by a high pulse of at least a programmable number of clock cycles. It also watches each completed serial control word. When that word arrives with its sleep bit cleared, the regulators are switched off, but only if the wake input is low at that moment. The sleep bit therefore has to be written as one in every control word for the supply to stay on.

A wake input tied high keeps the supply on regardless of what the control words say. On every exit from the off state the block samples a flag that says whether the main rail stayed above its retention level. It then pulses a restore strobe for one cycle, together with a select level. The select level tells the register bank whether to reload defaults or keep the last programmed values.

Between off and on there is a transition state of a configurable length. During that state the enable stays low. The enable is a flop output, so it cannot glitch.

Top module: `wake_sleep_pwr_ctl`

## Requirements
- R1: After reset, `reg_en`, `restore_pulse` and `restore_keep` are 0 and the block is off.
- R2: While off, a wake level that stays high starts the supply. Take the first rising clock edge that samples `wake_i` high as edge 0. `reg_en` becomes 1 on edge SYNC_STAGES+MIN_WAKE+START_CYC.
- R3: A wake pulse that is sampled high on at least MIN_WAKE consecutive edges starts the supply with the same timing as R2, even when `wake_i` has already returned low.
- R4: A wake pulse sampled high on fewer than MIN_WAKE consecutive edges is ignored, and `reg_en` stays 0.
- R5: While on, a `word_stb` cycle whose `ctrl_word` bit SLEEP_BIT (bit 8 by default) is 0 clears `reg_en` on that same edge. This happens only when the synchronized wake level is low.
- R6: While on, a sleep word (bit SLEEP_BIT = 0) arriving while the synchronized wake level is high has no effect, and `reg_en` stays 1.
- R7: While on, a control word with bit SLEEP_BIT = 1 keeps `reg_en` at 1.
- R8: On the edge that leaves the off state (edge SYNC_STAGES+MIN_WAKE in R2), `restore_pulse` becomes 1 for exactly one cycle. `restore_keep` takes the value of `rail_kept` sampled on that edge: 1 means keep the last control values, 0 means reload defaults.
- R9: `reg_en` stays 0 while `restore_pulse` is high and for the rest of the START_CYC-cycle transition. It rises only when the transition ends.
- R10: Control words received while off or during the transition, whatever their sleep bit, neither start nor stop the supply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | 1 | Wake request, asynchronous to clk |
| ctrl_word | input | CTRL_W | Latest completed serial control word |
| word_stb | input | 1 | One-cycle strobe marking a new control word |
| rail_kept | input | 1 | 1 when the main rail stayed above its retention level |
| reg_en | output | 1 | Registered enable for the switched regulators |
| restore_pulse | output | 1 | One-cycle strobe on exit from the off state |
| restore_keep | output | 1 | Restore select: 1 keep last values, 0 load defaults |

## Verification
The checker checks several rules on every cycle:
- the enable falls only on a sleep word seen with wake low;
- a strobe arriving with wake high or with the sleep bit set never drops the enable;
- the restore strobe lasts one cycle, never overlaps the enable, and carries the rail flag of its own edge;
- the enable rises only out of the transition state.

Some behaviour only the bench scenarios can show. These are the exact start-up latency, the dividing line between pulse widths that qualify and those that do not, and the fact that words arriving while off or in transition are ignored. The bench drives random pulse widths and word sequences across that boundary.

// File: rtl/wake_sleep_pwr_pkg.sv
package wake_sleep_pwr_pkg;

   typedef enum logic [1:0] {
      PS_OFF   = 2'd0,
      PS_START = 2'd1,
      PS_ON    = 2'd2
   } pwr_state_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= d_i;
               for (int k = 1; k < STAGES; k++) begin
                  chain_q[k] <= chain_q[k-1];
               end
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/wake_qual.sv
module wake_qual
   import wake_sleep_pwr_pkg::*;
#(
   parameter int unsigned MIN_WAKE = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_s,
   output logic wake_ok
);

   localparam int unsigned CNT_W = cnt_width(MIN_WAKE);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_WAKE);

   logic [CNT_W-1:0] hi_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt_q <= '0;
      end else if (!wake_s) begin
         hi_cnt_q <= '0;
      end else if (hi_cnt_q != CNT_MAX) begin
         hi_cnt_q <= hi_cnt_q + 1'b1;
      end
   end

   assign wake_ok = (hi_cnt_q == CNT_MAX);

endmodule

// File: rtl/sleep_gate.sv
module sleep_gate #(
   parameter int unsigned CTRL_W    = 16,
   parameter int unsigned SLEEP_BIT = 8
) (
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic              word_stb,
   input  logic              wake_s,
   output logic              sleep_req
);

   localparam logic [CTRL_W-1:0] SLEEP_MASK = CTRL_W'(1) << SLEEP_BIT;

   logic sleep_cmd;

   assign sleep_cmd = ((ctrl_word & SLEEP_MASK) == '0);
   assign sleep_req = word_stb & sleep_cmd & ~wake_s;

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
   import wake_sleep_pwr_pkg::*;
#(
   parameter int unsigned START_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_ok,
   input  logic sleep_req,
   input  logic rail_kept,
   output logic reg_en,
   output logic restore_pulse,
   output logic restore_keep,
   output logic in_start
);

   localparam int unsigned ST_W = cnt_width(START_CYC);
   localparam logic [ST_W-1:0] ST_LAST = ST_W'(START_CYC - 1);

   pwr_state_t state_q;
   logic [ST_W-1:0] st_cnt_q;
   logic st_done;

   generate
      if (START_CYC == 1) begin : g_single
         assign st_done = 1'b1;
      end else begin : g_count
         assign st_done = (st_cnt_q == ST_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= PS_OFF;
         st_cnt_q      <= '0;
         reg_en        <= 1'b0;
         restore_pulse <= 1'b0;
         restore_keep  <= 1'b0;
      end else begin
         restore_pulse <= 1'b0;
         case (state_q)
            PS_OFF: begin
               if (wake_ok) begin
                  state_q       <= PS_START;
                  st_cnt_q      <= '0;
                  restore_pulse <= 1'b1;
                  restore_keep  <= rail_kept;
               end
            end
            PS_START: begin
               if (st_done) begin
                  state_q <= PS_ON;
                  reg_en  <= 1'b1;
               end else begin
                  st_cnt_q <= st_cnt_q + 1'b1;
               end
            end
            PS_ON: begin
               if (sleep_req) begin
                  state_q <= PS_OFF;
                  reg_en  <= 1'b0;
               end
            end
            default: begin
               state_q <= PS_OFF;
               reg_en  <= 1'b0;
            end
         endcase
      end
   end

   assign in_start = (state_q == PS_START);

endmodule

// File: rtl/wake_sleep_pwr_ctl.sv
module wake_sleep_pwr_ctl #(
   parameter int unsigned CTRL_W      = 16,
   parameter int unsigned SLEEP_BIT   = 8,
   parameter int unsigned MIN_WAKE    = 2500,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned START_CYC   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wake_i,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic              word_stb,
   input  logic              rail_kept,
   output logic              reg_en,
   output logic              restore_pulse,
   output logic              restore_keep
);

   generate
      if (SLEEP_BIT >= CTRL_W) begin : g_bad_bit
         $error("SLEEP_BIT must index into ctrl_word");
      end
      if (MIN_WAKE < 1) begin : g_bad_wake
         $error("MIN_WAKE must be at least one cycle");
      end
      if (START_CYC < 1) begin : g_bad_start
         $error("START_CYC must be at least one cycle");
      end
   endgenerate

   logic wake_s;
   logic wake_ok;
   logic sleep_req;
   logic in_start;

   wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (wake_i),
      .q_o   (wake_s)
   );

   wake_qual #(.MIN_WAKE(MIN_WAKE)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .wake_s  (wake_s),
      .wake_ok (wake_ok)
   );

   sleep_gate #(.CTRL_W(CTRL_W), .SLEEP_BIT(SLEEP_BIT)) u_gate (
      .ctrl_word (ctrl_word),
      .word_stb  (word_stb),
      .wake_s    (wake_s),
      .sleep_req (sleep_req)
   );

   pwr_fsm #(.START_CYC(START_CYC)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .wake_ok       (wake_ok),
      .sleep_req     (sleep_req),
      .rail_kept     (rail_kept),
      .reg_en        (reg_en),
      .restore_pulse (restore_pulse),
      .restore_keep  (restore_keep),
      .in_start      (in_start)
   );

endmodule

// File: rtl/wake_sleep_pwr_ctl_chk.sv
module wake_sleep_pwr_ctl_chk #(
   parameter int unsigned CTRL_W    = 16,
   parameter int unsigned SLEEP_BIT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wake_s,
   input logic [CTRL_W-1:0] ctrl_word,
   input logic              word_stb,
   input logic              rail_kept,
   input logic              in_start,
   input logic              reg_en,
   input logic              restore_pulse,
   input logic              restore_keep
);

   // R5
   enable_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_en) |-> $past(word_stb && !ctrl_word[SLEEP_BIT] && !wake_s));

   // R6
   wake_blocks_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_en && word_stb && wake_s) |=> reg_en);

   // R7
   sleep_bit_set_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_en && word_stb && ctrl_word[SLEEP_BIT]) |=> reg_en);

   // R8
   restore_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restore_pulse |=> !restore_pulse);

   // R8
   restore_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restore_pulse) |-> (restore_keep == $past(rail_kept)));

   // R9
   restore_before_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restore_pulse |-> !reg_en);

   // R9
   enable_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_en) |-> $past(in_start));

endmodule

bind wake_sleep_pwr_ctl wake_sleep_pwr_ctl_chk #(
   .CTRL_W    (CTRL_W),
   .SLEEP_BIT (SLEEP_BIT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wake_s        (wake_s),
   .ctrl_word     (ctrl_word),
   .word_stb      (word_stb),
   .rail_kept     (rail_kept),
   .in_start      (in_start),
   .reg_en        (reg_en),
   .restore_pulse (restore_pulse),
   .restore_keep  (restore_keep)
);

// File: tb/tb_wake_sleep_pwr_ctl.sv
module tb_wake_sleep_pwr_ctl;

   localparam int CW = 16;
   localparam int SB = 8;
   localparam int NW = 8;
   localparam int SS = 2;
   localparam int SC = 2;
   localparam int T_LEAVE = SS + NW;
   localparam int T_ON    = SS + NW + SC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wake_i = 1'b0;
   logic [CW-1:0] ctrl_word = '0;
   logic          word_stb = 1'b0;
   logic          rail_kept = 1'b0;
   logic          reg_en;
   logic          restore_pulse;
   logic          restore_keep;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wake_sleep_pwr_ctl #(
      .CTRL_W(CW), .SLEEP_BIT(SB), .MIN_WAKE(NW),
      .SYNC_STAGES(SS), .START_CYC(SC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .ctrl_word(ctrl_word),
      .word_stb(word_stb), .rail_kept(rail_kept), .reg_en(reg_en),
      .restore_pulse(restore_pulse), .restore_keep(restore_keep)
   );

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   function automatic logic [CW-1:0] make_word(input logic sleep_bit);
      logic [CW-1:0] w;
      w = CW'($urandom);
      w[SB] = sleep_bit;
      return w;
   endfunction

   function automatic logic expect_start(input int width);
      return (width == 0) || (width >= NW);
   endfunction

   // width 0 means wake stays high; stb_mid drives a sleep word during the transition
   task automatic try_wake(input int width, input logic rail, input bit stb_mid);
      logic exp_on;
      exp_on = expect_start(width);
      rail_kept = rail;
      wake_i = 1'b1;
      for (int i = 1; i <= T_ON + 1; i++) begin
         step(1);
         if (i == width) wake_i = 1'b0;
         word_stb = 1'b0;
         if (i == T_LEAVE) check("R8 no early restore", restore_pulse, 1'b0);
         if (i == T_LEAVE + 1) begin
            check(width == 0 ? "R2 restore pulse" : (exp_on ? "R3 restore pulse" : "R4 no restore"),
                  restore_pulse, exp_on);
            if (exp_on) check("R8 restore select", restore_keep, rail);
            check("R9 enable low in transition", reg_en, 1'b0);
            if (stb_mid && exp_on) begin
               ctrl_word = make_word(1'b0);
               word_stb = 1'b1;
            end
         end
         if (i == T_LEAVE + 2 && exp_on) check("R8 single cycle", restore_pulse, 1'b0);
         if (i == T_ON) check("R9 enable low before end", reg_en, 1'b0);
      end
      check(width == 0 ? "R2 start" : (exp_on ? (stb_mid ? "R10 start despite word" : "R3 start")
                                                : "R4 ignored"), reg_en, exp_on);
   endtask

   task automatic send_word(input logic sleep_bit);
      ctrl_word = make_word(sleep_bit);
      word_stb = 1'b1;
      step(1);
      word_stb = 1'b0;
   endtask

   task automatic set_wake(input logic lvl);
      wake_i = lvl;
      step(SS + 2);
   endtask

   task automatic force_off();
      set_wake(1'b0);
      if (reg_en) send_word(1'b0);
      check("R5 forced off", reg_en, 1'b0);
      step(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      step(3);
      check("R1 reset enable", reg_en, 1'b0);
      check("R1 reset restore", restore_pulse, 1'b0);
      check("R1 reset select", restore_keep, 1'b0);
      rst_n = 1'b1;
      step(2);

      // R10: words while off do nothing
      send_word(1'b1);
      send_word(1'b0);
      step(T_ON + 2);
      check("R10 word while off", reg_en, 1'b0);

      // R4 boundary: one cycle short
      try_wake(NW - 1, 1'b1, 1'b0);
      step(SS + 3);
      // R3 boundary: exactly minimum, defaults path
      try_wake(NW, 1'b0, 1'b0);
      // R6: wake still low here, raise it then send sleep
      set_wake(1'b1);
      send_word(1'b0);
      check("R6 sleep blocked by wake", reg_en, 1'b1);
      // R7
      send_word(1'b1);
      check("R7 sleep bit set keeps on", reg_en, 1'b1);
      // R5
      set_wake(1'b0);
      send_word(1'b0);
      check("R5 sleep with wake low", reg_en, 1'b0);
      step(SS + 3);

      // R2 static wake, keep path, word during transition
      try_wake(0, 1'b1, 1'b1);
      send_word(1'b0);
      check("R6 static wake blocks sleep", reg_en, 1'b1);
      force_off();

      for (int t = 0; t < 40; t++) begin
         int w;
         w = int'($urandom_range(2 * NW, 0));
         try_wake(w, 1'($urandom), 1'($urandom_range(3, 0) == 0));
         if (reg_en) begin
            for (int k = 0; k < 5; k++) begin
               logic lvl;
               logic sb;
               logic exp;
               lvl = 1'($urandom);
               sb  = 1'($urandom);
               set_wake(lvl);
               exp = !(sb == 1'b0 && lvl == 1'b0);
               send_word(sb);
               check(sb ? "R7 random keep" : (lvl ? "R6 random blocked" : "R5 random sleep"),
                     reg_en, exp);
               if (!reg_en) break;
            end
            force_off();
         end
         set_wake(1'b0);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule